// File: doc/BRIEF.md
# Reconfigurable Majority Voting Manager

This block sits behind a set of redundant units that all compute the same word. It forms one voted word from the units that still take part, and checks every taking-part unit against that word. A unit that keeps disagreeing is marked failed and is dropped from later votes. The failed marks stay set until a reset or a per-unit re-enable pulse. The voted word, a valid flag and a mode code are registered, so they appear one clock after the unit words they come from.

Two degradation policies are selected by an input. With the single-survivor policy, the first failure drops the voter to one healthy unit: the lowest-numbered one, which then drives the output alone. With the spare-keeping policy, all healthy units keep voting. After the first failure this leaves a duplex pair. When the pair splits, the last good output serves as the reference, and this lets the block detect a second failure. The one good unit left after that drives the output alone.

Top module: `vote_manager`

## Requirements
- R1: Unit i occupies bits [i*DATA_W +: DATA_W] of `unitData`. When a word is held by strictly more than half of the taking-part units, `votedData` shows that word and `resultValid` is 1 on the clock after those inputs were present.
- R2: When no word reaches a strict majority of the taking-part units, `resultValid` is 0 on the next clock and `votedData` keeps the last valid word.
- R3: On a counted cycle, a taking-part unit that differs from the reference advances its miss count, and a unit that matches the reference restarts its count. A counted cycle is either a valid vote (the reference is the voted word) or a split duplex in which exactly one unit equals the held output (the reference is the held output). `failMask[i]` rises only when FAIL_LIMIT consecutive counted misses have occurred.
- R4: A unit with its `failMask` bit set does not take part in the vote and is never counted.
- R5: With `policySel`=0, no failures and every unit takes part. After any failure, only the lowest-numbered healthy unit takes part, and its word is passed through as a valid simplex result.
- R6: With `policySel`=1, every healthy unit takes part. A split duplex counts a miss against the unit that differs from the held output. Once a single unit is left, its word is the simplex result.
- R7: A split duplex in which neither unit equals the held output is not counted: no miss count moves and no unit is marked failed.
- R8: `failMask` bits are sticky. A bit clears only on `rst` or on a one-cycle pulse of `reenable[i]`, which also restarts that unit's miss count and takes priority over a failure in the same cycle.
- R9: `mode` is registered together with `resultValid`: 0 for three or more units in a valid vote, 1 for a valid duplex, 2 for a valid simplex, and 3 when there is no valid result.
- R10: After a synchronous reset, `votedData`=0, `resultValid`=0, `mode`=3 and `failMask`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| policySel | input | 1 | 0 = drop to one survivor on the first failure, 1 = keep all healthy units voting |
| reenable | input | NUM_UNITS | One-cycle pulse per unit that clears its failed mark |
| unitData | input | NUM_UNITS*DATA_W | Words of all units, unit 0 in the low bits |
| votedData | output | DATA_W | Registered voted word |
| resultValid | output | 1 | The registered word comes from a valid vote |
| failMask | output | NUM_UNITS | Sticky per-unit failed marks |
| mode | output | 2 | Registered redundancy level code |

## Verification
The bench builds the block with three units, 4-bit words and a failure limit of 2. With these values it can sweep all 4096 word triples in full triple mode. Each triple is followed by an agreeing cycle, so every single-cycle disagreement is also shown to leave the failed marks clear. The short limit lets a failure be reached in two cycles. This brings both degradation paths within reach in a short run: triple to simplex under either failing unit, and triple to duplex to simplex through the held-output reference. The same build covers re-enable priority and the uncounted duplex split.

// File: rtl/vote_pkg.sv
package vote_pkg;

  typedef enum logic [1:0] {
    MODE_TRIPLE  = 2'd0,
    MODE_DUPLEX  = 2'd1,
    MODE_SIMPLEX = 2'd2,
    MODE_NONE    = 2'd3
  } vote_mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadData;
    logic markValid;
  } vote_ctrl_t;

endpackage

// File: rtl/vote_datapath.sv
module vote_datapath
  import vote_pkg::*;
#(
  parameter int NUM_UNITS = 3,
  parameter int DATA_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_UNITS*DATA_W-1:0]   unitData,
  input  logic [NUM_UNITS-1:0]          partMask,
  input  vote_ctrl_t                    ctrl,
  output logic                          winnerOk,
  output logic [NUM_UNITS-1:0]          matchVote,
  output logic [NUM_UNITS-1:0]          matchHeld,
  output logic [DATA_W-1:0]             votedData,
  output logic                          resultValid
);

  localparam int CNT_W = $clog2(NUM_UNITS + 1);

  logic [DATA_W-1:0]    unitWord [NUM_UNITS];
  logic [NUM_UNITS-1:0] pairEq   [NUM_UNITS];
  logic [CNT_W-1:0]     agree    [NUM_UNITS];
  logic [CNT_W-1:0]     nPart;
  logic [DATA_W-1:0]    winnerVal;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_UNITS; gi++) begin : g_word
      assign unitWord[gi] = unitData[gi*DATA_W +: DATA_W];
    end
  endgenerate

  // pairwise equality restricted to taking-part units
  always_comb begin
    for (int i = 0; i < NUM_UNITS; i++) begin
      for (int j = 0; j < NUM_UNITS; j++) begin
        pairEq[i][j] = partMask[j] && (unitWord[i] == unitWord[j]);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_UNITS; i++) begin
      agree[i] = '0;
      for (int j = 0; j < NUM_UNITS; j++) begin
        agree[i] = agree[i] + CNT_W'(pairEq[i][j]);
      end
    end
  end

  always_comb begin
    nPart = '0;
    for (int j = 0; j < NUM_UNITS; j++) begin
      nPart = nPart + CNT_W'(partMask[j]);
    end
  end

  // strict majority winner; scanning downward leaves the lowest index
  always_comb begin
    winnerOk  = 1'b0;
    winnerVal = '0;
    for (int i = NUM_UNITS - 1; i >= 0; i--) begin
      if (partMask[i] && ({agree[i], 1'b0} > {1'b0, nPart})) begin
        winnerOk  = 1'b1;
        winnerVal = unitWord[i];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_UNITS; i++) begin
      matchVote[i] = (unitWord[i] == winnerVal);
      matchHeld[i] = (unitWord[i] == votedData);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      votedData   <= '0;
      resultValid <= 1'b0;
    end else begin
      if (ctrl.loadData) votedData <= winnerVal;
      resultValid <= ctrl.markValid;
    end
  end

  // R2
  hold_when_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    !resultValid |-> $stable(votedData));

endmodule

// File: rtl/vote_control.sv
module vote_control
  import vote_pkg::*;
#(
  parameter int NUM_UNITS  = 3,
  parameter int FAIL_LIMIT = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 policySel,
  input  logic [NUM_UNITS-1:0] reenable,
  input  logic                 winnerOk,
  input  logic [NUM_UNITS-1:0] matchVote,
  input  logic [NUM_UNITS-1:0] matchHeld,
  output logic [NUM_UNITS-1:0] partMask,
  output vote_ctrl_t           ctrl,
  output logic [NUM_UNITS-1:0] failMask,
  output logic [1:0]           mode
);

  localparam int CNT_W  = $clog2(NUM_UNITS + 1);
  localparam int MISS_W = $clog2(FAIL_LIMIT + 1);
  localparam logic [MISS_W-1:0] LAST_MISS = MISS_W'(FAIL_LIMIT - 1);

  logic [NUM_UNITS-1:0] failQ;
  logic [NUM_UNITS-1:0] lowestHealthy;
  logic [NUM_UNITS-1:0] missHit;
  logic [NUM_UNITS-1:0] refHit;
  logic [CNT_W-1:0]     nPart;
  logic                 dupRef;
  logic                 refOk;
  vote_mode_e           modeQ;
  vote_mode_e           modeNext;

  // one-hot of the lowest-numbered healthy unit
  always_comb begin
    lowestHealthy = '0;
    for (int i = NUM_UNITS - 1; i >= 0; i--) begin
      if (!failQ[i]) lowestHealthy = NUM_UNITS'(1) << i;
    end
  end

  // taking-part set follows the degradation policy
  always_comb begin
    if (policySel)         partMask = ~failQ;
    else if (failQ == '0)  partMask = '1;
    else                   partMask = lowestHealthy;
  end

  always_comb begin
    nPart = '0;
    for (int j = 0; j < NUM_UNITS; j++) nPart = nPart + CNT_W'(partMask[j]);
  end

  // split duplex judged against the held output when exactly one matches it
  assign dupRef = !winnerOk && (int'(nPart) == 2) &&
                  ($countones(partMask & matchHeld) == 1);
  assign refOk  = winnerOk || dupRef;

  always_comb begin
    for (int i = 0; i < NUM_UNITS; i++) begin
      missHit[i] = partMask[i] && refOk && !(winnerOk ? matchVote[i] : matchHeld[i]);
      refHit[i]  = partMask[i] && refOk &&  (winnerOk ? matchVote[i] : matchHeld[i]);
    end
  end

  genvar gu;
  generate
    for (gu = 0; gu < NUM_UNITS; gu++) begin : g_unit
      logic [MISS_W-1:0] missCnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          failQ[gu] <= 1'b0;
          missCnt   <= '0;
        end else if (reenable[gu]) begin
          failQ[gu] <= 1'b0;
          missCnt   <= '0;
        end else if (!partMask[gu]) begin
          missCnt   <= '0;
        end else if (missHit[gu]) begin
          if (missCnt == LAST_MISS) begin
            failQ[gu] <= 1'b1;
            missCnt   <= '0;
          end else begin
            missCnt   <= missCnt + 1'b1;
          end
        end else if (refHit[gu]) begin
          missCnt   <= '0;
        end
      end
    end
  endgenerate

  always_comb begin
    if (!winnerOk)             modeNext = MODE_NONE;
    else if (int'(nPart) >= 3) modeNext = MODE_TRIPLE;
    else if (int'(nPart) == 2) modeNext = MODE_DUPLEX;
    else                       modeNext = MODE_SIMPLEX;
  end

  always_ff @(posedge clk) begin
    if (rst) modeQ <= MODE_NONE;
    else     modeQ <= modeNext;
  end

  assign ctrl.loadData  = winnerOk;
  assign ctrl.markValid = winnerOk;
  assign failMask       = failQ;
  assign mode           = modeQ;

  // R8
  sticky_fail_chk: assert property (@(posedge clk) disable iff (rst)
    &(failQ | ~$past(failQ) | $past(reenable)));

  // R4
  fail_from_participant_chk: assert property (@(posedge clk) disable iff (rst)
    ((failQ & ~$past(failQ) & ~$past(partMask)) == '0));

endmodule

// File: rtl/vote_manager.sv
module vote_manager
  import vote_pkg::*;
#(
  parameter int NUM_UNITS  = 3,
  parameter int DATA_W     = 8,
  parameter int FAIL_LIMIT = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        policySel,
  input  logic [NUM_UNITS-1:0]        reenable,
  input  logic [NUM_UNITS*DATA_W-1:0] unitData,
  output logic [DATA_W-1:0]           votedData,
  output logic                        resultValid,
  output logic [NUM_UNITS-1:0]        failMask,
  output logic [1:0]                  mode
);

  logic [NUM_UNITS-1:0] partMask;
  logic [NUM_UNITS-1:0] matchVote;
  logic [NUM_UNITS-1:0] matchHeld;
  logic                 winnerOk;
  vote_ctrl_t           ctrl;

  vote_datapath #(.NUM_UNITS(NUM_UNITS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .unitData(unitData), .partMask(partMask),
    .ctrl(ctrl), .winnerOk(winnerOk), .matchVote(matchVote),
    .matchHeld(matchHeld), .votedData(votedData), .resultValid(resultValid)
  );

  vote_control #(.NUM_UNITS(NUM_UNITS), .FAIL_LIMIT(FAIL_LIMIT)) u_ctl (
    .clk(clk), .rst(rst), .policySel(policySel), .reenable(reenable),
    .winnerOk(winnerOk), .matchVote(matchVote), .matchHeld(matchHeld),
    .partMask(partMask), .ctrl(ctrl), .failMask(failMask), .mode(mode)
  );

  // R9
  mode_valid_agree_chk: assert property (@(posedge clk) disable iff (rst)
    resultValid == (mode != 2'd3));

endmodule

// File: tb/sim_vote_manager.sv
module sim_vote_manager;

  localparam int N = 3;
  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           policySel = 1'b0;
  logic [N-1:0]   reenable = '0;
  logic [N*W-1:0] unitData = '0;
  logic [W-1:0]   votedData;
  logic           resultValid;
  logic [N-1:0]   failMask;
  logic [1:0]     mode;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  vote_manager #(.NUM_UNITS(N), .DATA_W(W), .FAIL_LIMIT(2)) u0 (
    .clk(clk), .rst(rst), .policySel(policySel), .reenable(reenable),
    .unitData(unitData), .votedData(votedData), .resultValid(resultValid),
    .failMask(failMask), .mode(mode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int a, input int b, input int c, input logic [N-1:0] re);
    unitData = {W'(c), W'(b), W'(a)};
    reenable = re;
    @(posedge clk);
    #1;
    reenable = '0;
  endtask

  task automatic expectAll(input string tag, input int d, input int v, input int m, input int f);
    chk({tag, " data"}, int'(votedData), d);
    chk({tag, " valid"}, int'(resultValid), v);
    chk({tag, " mode"}, int'(mode), m);
    chk({tag, " mask"}, int'(failMask), f);
  endtask

  initial begin
    int held;
    @(posedge clk); #1;
    @(posedge clk); #1;
    expectAll("R10 reset", 0, 0, 3, 0);
    rst = 1'b0;

    // R1 R2 R3: all triples in triple mode, each followed by an agreeing cycle
    step(0, 0, 0, '0);
    held = 0;
    for (int idx = 0; idx < 4096; idx++) begin
      int a, b, c, k;
      a = idx & 15; b = (idx >> 4) & 15; c = (idx >> 8) & 15;
      step(a, b, c, '0);
      if (a == b || a == c)  begin expectAll("R1 sweep", a, 1, 0, 0); held = a; end
      else if (b == c)       begin expectAll("R1 sweep", b, 1, 0, 0); held = b; end
      else                   expectAll("R2 sweep hold", held, 0, 3, 0);
      k = (a ^ (b << 1) ^ c) & 15;
      step(k, k, k, '0);
      expectAll("R3 transient cleared", k, 1, 0, 0);
      held = k;
    end

    // policy 0: unit 2 fails, simplex on unit 0
    step(1, 1, 1, '0);  expectAll("R1 clean", 1, 1, 0, 0);
    step(1, 1, 9, '0);  expectAll("R3 one miss", 1, 1, 0, 0);
    step(1, 1, 9, '0);  expectAll("R3 limit reached", 1, 1, 0, 4);
    step(5, 9, 5, '0);  expectAll("R5 simplex unit0", 5, 1, 2, 4);
    step(6, 7, 7, '0);  expectAll("R4 R5 others ignored", 6, 1, 2, 4);
    for (int r = 0; r < 3; r++) begin
      step(6, 6, 6, '0); chk("R8 sticky mask", int'(failMask), 4);
    end
    step(6, 6, 6, 3'b100); expectAll("R8 reenable", 6, 1, 2, 0);
    step(4, 4, 4, '0);  expectAll("R9 back to triple", 4, 1, 0, 0);

    // policy 0: unit 0 fails, simplex on unit 1
    step(2, 3, 3, '0);  expectAll("R3 unit0 miss", 3, 1, 0, 0);
    step(2, 3, 3, '0);  expectAll("R3 unit0 failed", 3, 1, 0, 1);
    step(8, 5, 9, '0);  expectAll("R5 lowest healthy unit1", 5, 1, 2, 1);
    step(8, 8, 8, 3'b001); chk("R8 reenable unit0", int'(failMask), 0);
    step(7, 0, 0, '0);  chk("R8 prep miss", int'(failMask), 0);
    step(7, 0, 0, 3'b001); chk("R8 reenable wins", int'(failMask), 0);
    step(7, 0, 0, '0);  chk("R8 count restarted", int'(failMask), 0);
    step(0, 0, 0, '0);  expectAll("R1 clean", 0, 1, 0, 0);

    // policy 1: duplex, held-output reference, simplex
    policySel = 1'b1;
    step(9, 3, 3, '0);  expectAll("R6 unit0 miss", 3, 1, 0, 0);
    step(9, 3, 3, '0);  expectAll("R6 unit0 failed", 3, 1, 0, 1);
    step(9, 6, 6, '0);  expectAll("R4 R6 duplex", 6, 1, 1, 1);
    step(0, 6, 7, '0);  expectAll("R2 R6 split hold", 6, 0, 3, 1);
    step(0, 6, 6, '0);  expectAll("R3 duplex recovers", 6, 1, 1, 1);
    step(0, 1, 2, '0);  expectAll("R7 no reference", 6, 0, 3, 1);
    step(0, 1, 2, '0);  expectAll("R7 still uncounted", 6, 0, 3, 1);
    step(0, 6, 7, '0);  expectAll("R6 first split miss", 6, 0, 3, 1);
    step(0, 6, 7, '0);  expectAll("R6 second failure", 6, 0, 3, 5);
    step(0, 8, 2, '0);  expectAll("R6 simplex unit1", 8, 1, 2, 5);

    rst = 1'b1;
    step(0, 8, 2, '0);
    expectAll("R10 reset again", 0, 0, 3, 0);
    rst = 1'b0;

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog all requirements actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule